// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an up-counting timer and a watchdog counter. A single power-of-two prescaler is lent to one of them at a time. A small configuration word sets four things: where timer events come from (every instruction clock, or edges on an external pin), which pin edge counts, which counter owns the prescaler, and a three-bit rate code. The rate code means something different for each owner. For the timer it divides by 2 to 256. For the watchdog it divides by 1 to 128. The timer runs undivided only when the prescaler has been handed to the watchdog.

The timer wraps from all ones to zero and raises a sticky overflow flag, which is cleared by a separate command. The watchdog advances on a slow tick, directly or through the prescaler. When its counter passes its maximum, it raises a reset request that is held until the block's reset. A clear or sleep command restarts the watchdog count before that happens.

Top module: `tmr_wdt_presc`

## Requirements
- R1: After reset the timer is 0, the overflow flag and the timeout request are 0, and the configuration word is all ones (external source, falling edge, prescaler owned by the watchdog, rate code 7).
- R2: Configuration word layout: bits [2:0] rate code, bit 3 owner (1 = watchdog, 0 = timer), bit 4 edge (1 = falling, 0 = rising), bit 5 source (1 = external pin, 0 = instruction clock). A write takes effect from the next cycle.
- R3: With the prescaler owned by the timer and rate code r, the timer advances once per 2^(r+1) source events.
- R4: A timer write loads the written value in the next cycle. When the timer owns the prescaler, the write also clears the prescaler.
- R5: With the prescaler owned by the watchdog, the timer advances once per source event.
- R6: The external pin passes through a two-stage synchroniser. With the pin changing just after clock edge 0, the timer value changes after clock edge 3 and not before. Only the selected edge direction counts.
- R7: The timer wraps from 0xFF to 0x00 and sets the overflow flag. The flag stays set until an overflow-clear command.
- R8: With the prescaler owned by the watchdog and rate code r, the watchdog advances once per 2^r ticks. Otherwise it advances once per tick.
- R9: The timeout request rises on the watchdog step that follows its counter reaching all ones (2^WDT_W steps after a clear). It stays high until reset.
- R10: A watchdog clear or sleep command zeroes the watchdog counter. When the watchdog owns the prescaler, the command also zeroes the prescaler.
- R11: A configuration write zeroes the prescaler, and no prescaled step is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External timer clock pin, asynchronous |
| wdt_tick | input | 1 | Watchdog time base tick, one cycle per tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | TMR_W | Timer write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear command |
| sleep_cmd | input | 1 | Sleep command, also restarts the watchdog |
| tmr_value | output | TMR_W | Current timer count |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | Watchdog reset request |

## Verification
The assertions assume that every command input is synchronous to the clock. Only the external pin may change freely, and a timer write is taken to override any step in its cycle. The undivided-count and single-step properties also assume that a configuration write does not coincide with a timer event the bench is counting. The stimulus changes all inputs half a period away from the rising edge, holds the pin level for at least three clocks between transitions, and issues each configuration or timer write as an isolated one-cycle strobe.

// File: rtl/tmr_wdt_presc.sv
module tmr_wdt_presc #(
  parameter int TMR_W = 8,
  parameter int PRE_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_wdata,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             ovf_clr,
  input  logic             wdt_clr,
  input  logic             sleep_cmd,
  output logic [TMR_W-1:0] tmr_value,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);
  localparam logic [PRE_W:0]   P_ONE = {{PRE_W{1'b0}}, 1'b1};
  localparam logic [TMR_W-1:0] T_ONE = {{(TMR_W-1){1'b0}}, 1'b1};
  localparam logic [WDT_W-1:0] W_ONE = {{(WDT_W-1){1'b0}}, 1'b1};

  logic [5:0]       cfg;
  logic [2:0]       pin_sync;
  logic [PRE_W-1:0] presc;
  logic [WDT_W-1:0] wdt_cnt;

  wire [2:0] rate     = cfg[2:0];
  wire       to_wdt   = cfg[3];
  wire       fall_sel = cfg[4];
  wire       ext_sel  = cfg[5];

  wire ext_evt = fall_sel ? (pin_sync[2] & ~pin_sync[1]) : (pin_sync[1] & ~pin_sync[2]);
  wire src_evt = ext_sel ? ext_evt : 1'b1;

  wire [3:0]       tshift  = {1'b0, rate} + 4'd1;
  wire [PRE_W:0]   tm_full = (P_ONE << tshift) - P_ONE;
  wire [PRE_W:0]   wm_full = (P_ONE << rate) - P_ONE;
  wire [PRE_W-1:0] pmask   = to_wdt ? wm_full[PRE_W-1:0] : tm_full[PRE_W-1:0];

  wire presc_evt  = to_wdt ? wdt_tick : src_evt;
  wire presc_fire = presc_evt && ((presc & pmask) == pmask) && !cfg_we;
  wire wdt_kick   = wdt_clr | sleep_cmd;
  wire tmr_step   = to_wdt ? src_evt : presc_fire;
  wire wdt_step   = to_wdt ? presc_fire : wdt_tick;
  wire presc_zero = cfg_we || (tmr_we && !to_wdt) || (wdt_kick && to_wdt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg      <= '1;
      pin_sync <= '0;
    end else begin
      pin_sync <= {pin_sync[1:0], ext_pin};
      if (cfg_we) cfg <= cfg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          presc <= '0;
    else if (presc_zero) presc <= '0;
    else if (presc_evt)  presc <= presc + P_ONE[PRE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_value <= '0;
      tmr_ovf   <= 1'b0;
    end else begin
      if (tmr_we)        tmr_value <= tmr_wdata;
      else if (tmr_step) tmr_value <= tmr_value + T_ONE;
      if (tmr_step && !tmr_we && (&tmr_value)) tmr_ovf <= 1'b1;
      else if (ovf_clr)                        tmr_ovf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wdt_cnt     <= '0;
      wdt_timeout <= 1'b0;
    end else begin
      if (wdt_kick)      wdt_cnt <= '0;
      else if (wdt_step) wdt_cnt <= wdt_cnt + W_ONE;
      if (wdt_step && !wdt_kick && (&wdt_cnt)) wdt_timeout <= 1'b1;
    end

  a_r4_tmr_load: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_value == $past(tmr_wdata));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_value == $past(tmr_value)) || (tmr_value == $past(tmr_value) + T_ONE));
  a_r5_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    (to_wdt && !ext_sel && !tmr_we && !cfg_we) |=> tmr_value == $past(tmr_value) + T_ONE);
  a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && !ovf_clr) |=> tmr_ovf);
  a_r9_timeout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> wdt_timeout);
  a_r10_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |=> (wdt_cnt == '0) && !$rose(wdt_timeout));
endmodule

// File: tb/tb_tmr_wdt_presc.sv
module tb_tmr_wdt_presc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, wdt_tick = 1'b0, cfg_we = 1'b0, tmr_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [7:0] tmr_wdata = '0;
  logic       ovf_clr = 1'b0, wdt_clr = 1'b0, sleep_cmd = 1'b0;
  logic [7:0] tmr_value;
  logic       tmr_ovf, wdt_timeout;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tmr_wdt_presc dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wdt_tick(wdt_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .ovf_clr(ovf_clr), .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd),
    .tmr_value(tmr_value), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout));

  function automatic logic [5:0] cfgv(bit src, bit fall, bit own, logic [2:0] r);
    return {src, fall, own, r};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_pin = 1'b0; wdt_tick = 1'b0; cfg_we = 1'b0; tmr_we = 1'b0;
    ovf_clr = 1'b0; wdt_clr = 1'b0; sleep_cmd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(logic [5:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_tmr(logic [7:0] v);
    @(negedge clk); tmr_we = 1'b1; tmr_wdata = v;
    @(negedge clk); tmr_we = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); wdt_tick = 1'b1;
      repeat (n) @(negedge clk);
      wdt_tick = 1'b0;
    end
  endtask

  task automatic kick(bit use_sleep);
    @(negedge clk);
    if (use_sleep) sleep_cmd = 1'b1; else wdt_clr = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0; wdt_clr = 1'b0;
  endtask

  task automatic set_pin(bit v);
    @(negedge clk); ext_pin = v;
  endtask

  task automatic t_reset_state();
    do_reset();
    step(1);
    chk("R1 timer", tmr_value, 0);
    chk("R1 ovf", tmr_ovf, 0);
    chk("R1 timeout", wdt_timeout, 0);
    step(20);
    chk("R1 external source idle", tmr_value, 0);
  endtask

  task automatic t_reset_edge();
    set_pin(1'b1); step(5);
    chk("R1 rising ignored by falling default", tmr_value, 0);
    set_pin(1'b0); step(2);
    chk("R6 not before third edge", tmr_value, 0);
    step(1);
    chk("R6 falling counted 1:1", tmr_value, 1);
  endtask

  task automatic t_reset_wdt();
    ticks(32767);
    chk("R1 R8 rate 7 watchdog before", wdt_timeout, 0);
    ticks(1);
    chk("R1 R8 rate 7 watchdog at 32768", wdt_timeout, 1);
  endtask

  task automatic t_rising();
    do_reset();
    set_cfg(cfgv(1, 0, 1, 0));
    wr_tmr(8'd0);
    set_pin(1'b1); step(2);
    chk("R6 rise pending", tmr_value, 0);
    step(1);
    chk("R6 rise counted", tmr_value, 1);
    set_pin(1'b0); step(6);
    chk("R6 fall ignored", tmr_value, 1);
  endtask

  task automatic t_divide();
    set_cfg(cfgv(0, 0, 0, 0)); wr_tmr(8'd0); step(10);
    chk("R2 R3 div2", tmr_value, 5);
    set_cfg(cfgv(0, 0, 0, 3)); wr_tmr(8'd0); step(48);
    chk("R3 div16", tmr_value, 3);
    set_cfg(cfgv(0, 0, 0, 7)); wr_tmr(8'd0); step(511);
    chk("R3 div256 before", tmr_value, 1);
    step(1);
    chk("R3 div256 at", tmr_value, 2);
  endtask

  task automatic t_undivided();
    set_cfg(cfgv(0, 0, 1, 5)); wr_tmr(8'h10); step(7);
    chk("R2 R5 undivided", tmr_value, 8'h17);
  endtask

  task automatic t_write_clears();
    set_cfg(cfgv(0, 0, 0, 1)); wr_tmr(8'd0); step(3);
    chk("R4 before write", tmr_value, 0);
    wr_tmr(8'd10);
    chk("R4 loaded", tmr_value, 10);
    step(3);
    chk("R4 prescaler cleared", tmr_value, 10);
    step(1);
    chk("R4 next tick", tmr_value, 11);
  endtask

  task automatic t_cfg_clears();
    set_cfg(cfgv(0, 0, 0, 1)); wr_tmr(8'd0); step(3);
    set_cfg(cfgv(0, 0, 0, 1));
    step(3);
    chk("R11 cfg write clears prescaler", tmr_value, 0);
    step(1);
    chk("R11 next tick", tmr_value, 1);
  endtask

  task automatic t_wrap();
    set_cfg(cfgv(0, 0, 1, 0)); wr_tmr(8'hFE); step(1);
    chk("R7 at FF", tmr_value, 8'hFF);
    chk("R7 no flag yet", tmr_ovf, 0);
    step(1);
    chk("R7 wrapped", tmr_value, 0);
    chk("R7 flag set", tmr_ovf, 1);
    step(5);
    chk("R7 flag sticky", tmr_ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R7 flag cleared", tmr_ovf, 0);
  endtask

  task automatic t_wdt_direct();
    do_reset();
    set_cfg(cfgv(1, 0, 0, 0)); kick(1'b0);
    ticks(255);
    chk("R8 R9 direct before", wdt_timeout, 0);
    ticks(1);
    chk("R9 timeout at 256", wdt_timeout, 1);
    kick(1'b0); step(3);
    chk("R9 timeout held", wdt_timeout, 1);
  endtask

  task automatic t_wdt_clear(bit use_sleep);
    do_reset();
    set_cfg(cfgv(1, 0, 0, 0));
    ticks(200); kick(use_sleep); ticks(255);
    chk(use_sleep ? "R10 sleep restarts" : "R10 clear restarts", wdt_timeout, 0);
    ticks(1);
    chk("R10 timeout after restart", wdt_timeout, 1);
  endtask

  task automatic t_wdt_presc();
    do_reset();
    set_cfg(cfgv(1, 0, 1, 2)); kick(1'b0);
    ticks(1023);
    chk("R8 div4 before", wdt_timeout, 0);
    ticks(1);
    chk("R8 div4 at 1024", wdt_timeout, 1);
    do_reset();
    set_cfg(cfgv(1, 0, 1, 3)); kick(1'b0);
    ticks(7); kick(1'b0); ticks(2047);
    chk("R10 prescaler cleared by clear", wdt_timeout, 0);
    ticks(1);
    chk("R10 timeout at 2048", wdt_timeout, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_reset_edge();
    t_reset_wdt();
    t_rising();
    t_divide();
    t_undivided();
    t_write_clears();
    t_cfg_clears();
    t_wrap();
    t_wdt_direct();
    t_wdt_clear(1'b0);
    t_wdt_clear(1'b1);
    t_wdt_presc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule